// File: doc/BRIEF.md
# Strobed Parallel Input Capture Controller

This block samples a 32-bit parallel input bus and offers each sampled word to a downstream FIFO over a valid/ready push port. It can take its sampling event from three sources, selected by a two-bit mode field. The first is a single-cycle pacer tick from an on-chip timer. The second is an edge of an external request strobe, with the active edge chosen by a polarity bit. The third is a four-phase request/acknowledge handshake with the external sender. All captures can be held back until an external trigger edge of a chosen polarity has been seen.

The external request and trigger pins pass through a two-flop synchroniser before any edge or level is used. Strobe-mode samples are spaced at least `MIN_GAP` clock cycles apart, and edges that come sooner are discarded. A sticky overrun flag records any word that was lost because the FIFO was full. The host clears the flag with a clear pulse or with a flush, which also disarms the trigger.

Back-pressure rules on the push port: `m_ready` low means the FIFO is full. In pacer mode, strobe mode, and handshake mode with the acknowledge gate off, `m_valid` is a one-cycle offer. If `m_ready` is low in that cycle the word is lost and overrun is set. In handshake mode with the acknowledge gate on, `m_valid` is held with `m_data` stable until `m_ready` is high. No word is ever lost in that case, and the acknowledge to the sender waits for the acceptance.

Top module: `par_capture`

## Requirements
- R1: After reset, `m_valid`, `ext_ack`, `overrun` and `trig_seen` are all 0.
- R2: With `cfg_mode`=0 (pacer) and the gate open, a cycle with `pacer_tick`=1 makes `m_valid`=1 in the next cycle, for one cycle only. `m_data` in that cycle equals `ext_data` from the tick cycle.
- R3: With `cfg_mode`=1 (strobe), the active edge of `ext_req` is rising when `cfg_edge_fall`=0 and falling when it is 1, and the other edge is ignored. If `ext_req` changes before clock edge k, `m_valid` is 1 in the cycle after edge k+2 and only in that cycle.
- R4: In strobe mode, two accepted captures are at least `MIN_GAP` (default 5) cycles apart. An active edge that comes sooner is dropped, and no capture is made for it later.
- R5: With `cfg_mode`=2 (handshake), a synchronised high `ext_req` produces exactly one capture. `ext_ack` rises 4 cycles after `ext_req` rises at the pin, which is 2 cycles after the synchronised request is seen. `ext_ack` stays high until the synchronised request falls.
- R6: In handshake mode with `cfg_ack_en`=1, `m_valid` is held with stable `m_data` while `m_ready`=0. `ext_ack` rises on the clock edge that accepts the word, and never before it.
- R7: When a one-cycle offer meets `m_ready`=0, the word is not pushed and `overrun` becomes 1 on the next cycle.
- R8: `overrun` stays 1 until an `ovr_clr` or `flush` pulse clears it. If a drop and a clear fall in the same cycle, the flag stays set.
- R9: With `cfg_trig_en`=1, no capture occurs until a synchronised `ext_trig` edge is seen. The edge is rising when `cfg_trig_fall`=0 and falling when it is 1. `trig_seen` then stays 1 until `flush`.
- R10: With `cfg_mode`=3, no source causes a capture and `ext_ack` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Source select: 0 pacer, 1 strobe, 2 handshake, 3 off |
| cfg_edge_fall | input | 1 | Strobe active edge: 0 rising, 1 falling |
| cfg_trig_en | input | 1 | Hold captures until a trigger edge is seen |
| cfg_trig_fall | input | 1 | Trigger edge: 0 rising, 1 falling |
| cfg_ack_en | input | 1 | Handshake acknowledge waits for FIFO acceptance |
| pacer_tick | input | 1 | Single-cycle sampling tick from the timer |
| ext_data | input | DATA_W | Parallel input word |
| ext_req | input | 1 | External request / strobe (asynchronous) |
| ext_trig | input | 1 | External start trigger (asynchronous) |
| ext_ack | output | 1 | Acknowledge to the external sender |
| m_valid | output | 1 | Word offered to the FIFO |
| m_data | output | DATA_W | Offered word |
| m_ready | input | 1 | FIFO not full |
| ovr_clr | input | 1 | Host write-one pulse clearing overrun |
| flush | input | 1 | FIFO clear command: clears overrun and the trigger arm |
| overrun | output | 1 | Sticky lost-word flag |
| trig_seen | output | 1 | Trigger has been seen |

## Verification
A word can be dropped in the same cycle as the host's overrun clear pulse. The bench provokes this with a pacer tick while `m_ready` is low, then raises `ovr_clr` in the cycle the lost offer is on the port. The flag must read 1 afterwards, and a later lone clear must bring it to 0. Sweeps over strobe edge spacing, data patterns with a ready pattern, and both polarities are counted arithmetically against the pushes seen at the port.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
  typedef enum logic [1:0] {
    SRC_PACER     = 2'd0,
    SRC_STROBE    = 2'd1,
    SRC_HANDSHAKE = 2'd2,
    SRC_OFF       = 2'd3
  } src_mode_e;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_HOLD = 2'd1,
    HS_ACK  = 2'd2
  } hs_state_e;
endpackage

// File: rtl/pcap_sync.sv
module pcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic fall_sel,
  output logic level,
  output logic edge_p
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign level  = chain[STAGES-1];
  assign edge_p = fall_sel ? (chain[STAGES] & ~level) : (~chain[STAGES] & level);
endmodule

// File: rtl/pcap_gap.sv
module pcap_gap #(
  parameter int MIN_GAP = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic open_o
);
  localparam int GW = $clog2(MIN_GAP + 1);
  logic [GW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (fire)      cnt <= GW'(MIN_GAP - 1);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign open_o = (cnt == '0);
endmodule

// File: rtl/pcap_handshake.sv
module pcap_handshake
  import pcap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic req_lvl,
  input  logic ack_en,
  input  logic accepted,
  output logic load,
  output logic wait_ready,
  output logic ack
);
  hs_state_e state;

  assign load       = (state == HS_IDLE) & enable & req_lvl;
  assign wait_ready = (state == HS_HOLD) & ack_en;
  assign ack        = (state == HS_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= HS_IDLE;
    else begin
      case (state)
        HS_IDLE: if (load) state <= HS_HOLD;
        HS_HOLD: if (!ack_en || accepted) state <= HS_ACK;
        HS_ACK:  if (!req_lvl) state <= HS_IDLE;
        default: state <= HS_IDLE;
      endcase
    end
  end

  // R5: acknowledge rises two cycles after the synchronised request was seen
  assert_ack_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(req_lvl, 2));

  // R5: acknowledge is held while the request is still high
  assert_ack_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req_lvl) |=> ack);

  // R6: with the gate on, acknowledge follows FIFO acceptance
  assert_ack_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack) && ack_en) |-> $past(accepted));
endmodule

// File: rtl/par_capture.sv
module par_capture
  import pcap_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_GAP     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_edge_fall,
  input  logic              cfg_trig_en,
  input  logic              cfg_trig_fall,
  input  logic              cfg_ack_en,
  input  logic              pacer_tick,
  input  logic [DATA_W-1:0] ext_data,
  input  logic              ext_req,
  input  logic              ext_trig,
  output logic              ext_ack,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  input  logic              m_ready,
  input  logic              ovr_clr,
  input  logic              flush,
  output logic              overrun,
  output logic              trig_seen
);
  localparam int CW = $clog2(MIN_GAP + 1);

  src_mode_e mode;
  logic req_lvl, req_edge, trig_lvl, trig_edge;
  logic gate, gap_open, strobe_fire, pacer_fire, hs_en, hs_load, hs_wait;
  logic load_any, accepted, drop;

  assign mode = src_mode_e'(cfg_mode);

  pcap_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_req), .fall_sel(cfg_edge_fall),
    .level(req_lvl), .edge_p(req_edge));

  pcap_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_trig), .fall_sel(cfg_trig_fall),
    .level(trig_lvl), .edge_p(trig_edge));

  // Trigger arm
  always_ff @(posedge clk) begin
    if (!rst_n || flush)                trig_seen <= 1'b0;
    else if (cfg_trig_en && trig_edge)  trig_seen <= 1'b1;
  end

  assign gate        = ~cfg_trig_en | trig_seen;
  assign pacer_fire  = gate & (mode == SRC_PACER) & pacer_tick;
  assign strobe_fire = gate & (mode == SRC_STROBE) & req_edge & gap_open;
  assign hs_en       = gate & (mode == SRC_HANDSHAKE);

  pcap_gap #(.MIN_GAP(MIN_GAP)) u_gap (
    .clk(clk), .rst_n(rst_n), .fire(strobe_fire), .open_o(gap_open));

  pcap_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .enable(hs_en), .req_lvl(req_lvl),
    .ack_en(cfg_ack_en), .accepted(accepted),
    .load(hs_load), .wait_ready(hs_wait), .ack(ext_ack));

  assign load_any = pacer_fire | strobe_fire | hs_load;
  assign accepted = m_valid & m_ready;
  assign drop     = m_valid & ~m_ready & ~hs_wait;

  // Push register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (load_any) begin
      m_valid <= 1'b1;
      m_data  <= ext_data;
    end else if (m_valid && !(hs_wait && !m_ready)) begin
      m_valid <= 1'b0;
    end
  end

  // Sticky overrun: a new drop wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)                overrun <= 1'b0;
    else if (drop)             overrun <= 1'b1;
    else if (ovr_clr || flush) overrun <= 1'b0;
  end

  // Checker counter: cycles since the last accepted strobe capture
  logic [CW-1:0] chk_since;
  always_ff @(posedge clk) begin
    if (!rst_n)                       chk_since <= CW'(MIN_GAP);
    else if (strobe_fire)             chk_since <= CW'(1);
    else if (chk_since < CW'(MIN_GAP)) chk_since <= chk_since + 1'b1;
  end

  // R4: strobe captures never closer than MIN_GAP cycles
  assert_strobe_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_fire |-> (chk_since >= CW'(MIN_GAP)));

  // R7: a lost offer raises the overrun flag on the next cycle
  assert_drop_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overrun);

  // R6: a held offer keeps valid and data stable
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && hs_wait && !m_ready) |=> (m_valid && $stable(m_data)));

  // R9: a detected trigger edge leaves the synchronised level at the selected polarity
  assert_trig_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_edge |-> (trig_lvl != cfg_trig_fall));
endmodule

// File: tb/par_capture_bench.sv
module par_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_mode;
  logic        cfg_edge_fall, cfg_trig_en, cfg_trig_fall, cfg_ack_en;
  logic        pacer_tick;
  logic [31:0] ext_data;
  logic        ext_req, ext_trig, ext_ack;
  logic        m_valid, m_ready;
  logic [31:0] m_data;
  logic        ovr_clr, flush, overrun, trig_seen;

  int checks = 0;
  int failures = 0;
  int pushes = 0;
  logic [31:0] last_word = '0;
  bit done = 0;

  always #10 clk = ~clk;

  par_capture u_par_capture (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_edge_fall(cfg_edge_fall),
    .cfg_trig_en(cfg_trig_en), .cfg_trig_fall(cfg_trig_fall), .cfg_ack_en(cfg_ack_en),
    .pacer_tick(pacer_tick), .ext_data(ext_data), .ext_req(ext_req), .ext_trig(ext_trig),
    .ext_ack(ext_ack), .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready),
    .ovr_clr(ovr_clr), .flush(flush), .overrun(overrun), .trig_seen(trig_seen));

  always @(posedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      pushes    <= pushes + 1;
      last_word <= m_data;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int base, n, expect_push;
    rst_n = 0; cfg_mode = 0; cfg_edge_fall = 0; cfg_trig_en = 0; cfg_trig_fall = 0;
    cfg_ack_en = 0; pacer_tick = 0; ext_data = 0; ext_req = 0; ext_trig = 0;
    m_ready = 1; ovr_clr = 0; flush = 0;
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    chk("R1 m_valid", m_valid, 0);
    chk("R1 ext_ack", ext_ack, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 trig_seen", trig_seen, 0);

    // R2 / R7 pacer sweep with a ready pattern
    base = pushes; expect_push = 0;
    for (int i = 0; i < 8; i++) begin
      ext_data   = 32'hA500_0000 + i * 32'h0001_0203;
      m_ready    = (i % 3) != 0;
      if (m_ready) expect_push++;
      pacer_tick = 1;
      cyc(1);
      pacer_tick = 0;
      chk("R2 pacer valid", m_valid, 1);
      chk("R2 pacer data", m_data, 32'hA500_0000 + i * 32'h0001_0203);
      cyc(1);
      chk("R2 pacer single cycle", m_valid, 0);
    end
    m_ready = 1;
    cyc(1);
    chk("R7 pushes with ready pattern", pushes - base, expect_push);
    chk("R7 overrun after drop", overrun, 1);
    ovr_clr = 1; cyc(1); ovr_clr = 0;
    chk("R8 clear pulse", overrun, 0);

    // R8 drop and clear in the same cycle
    m_ready = 0; pacer_tick = 1; cyc(1);
    pacer_tick = 0; ovr_clr = 1; cyc(1);
    ovr_clr = 0;
    chk("r8_collision set wins", overrun, 1);
    cyc(2);
    chk("R8 sticky", overrun, 1);
    m_ready = 1; flush = 1; cyc(1); flush = 0;
    chk("R8 flush clears", overrun, 0);

    // R3 strobe both polarities with exact latency
    cfg_mode = 1;
    for (int f = 0; f < 2; f++) begin
      cfg_edge_fall = f[0];
      cyc(1);
      ext_req = f[0];
      cyc(8);
      base = pushes;
      ext_data = 32'h5A5A_0000 | f;
      ext_req = ~f[0];
      cyc(2);
      chk("R3 strobe not yet", m_valid, 0);
      cyc(1);
      chk("R3 strobe valid", m_valid, 1);
      chk("R3 strobe data", m_data, 32'h5A5A_0000 | f);
      cyc(1);
      chk("R3 strobe one cycle", m_valid, 0);
      ext_req = f[0];
      cyc(8);
      chk("R3 inactive edge ignored", pushes - base, 1);
    end
    cfg_edge_fall = 0; cyc(1); ext_req = 0; cyc(8);

    // R4 edge spacing sweep
    for (int g = 2; g <= 8; g++) begin
      base = pushes;
      ext_req = 1; cyc(1); ext_req = 0; cyc(g - 1);
      ext_req = 1; cyc(1); ext_req = 0; cyc(10);
      chk("R4 spacing sweep", pushes - base, (g >= 5) ? 2 : 1);
    end

    // R5 handshake, acknowledge gate off
    cfg_mode = 2; cfg_ack_en = 0; base = pushes;
    ext_data = 32'hC0DE_0001;
    ext_req = 1; n = 0;
    do begin cyc(1); n++; end while (!ext_ack && n < 20);
    chk("R5 ack latency", n, 4);
    cyc(3);
    chk("R5 ack held", ext_ack, 1);
    ext_req = 0; n = 0;
    do begin cyc(1); n++; end while (ext_ack && n < 20);
    chk("R5 ack released", ext_ack, 0);
    cyc(4);
    chk("R5 one capture", pushes - base, 1);
    chk("R5 data", last_word, 32'hC0DE_0001);

    // R7 handshake drop with gate off
    m_ready = 0; base = pushes;
    ext_req = 1; cyc(6);
    chk("R7 ack despite drop", ext_ack, 1);
    chk("R7 hs overrun", overrun, 1);
    ext_req = 0; cyc(6);
    chk("R7 nothing pushed", pushes - base, 0);
    flush = 1; cyc(1); flush = 0; m_ready = 1;

    // R6 handshake, acknowledge gate on
    cfg_ack_en = 1; m_ready = 0; base = pushes;
    ext_data = 32'hBEEF_0006;
    ext_req = 1; cyc(8);
    ext_data = 32'h0;
    chk("R6 ack waits", ext_ack, 0);
    chk("R6 valid held", m_valid, 1);
    chk("R6 data held", m_data, 32'hBEEF_0006);
    chk("R6 no overrun", overrun, 0);
    m_ready = 1; cyc(1);
    chk("R6 ack on accept", ext_ack, 1);
    chk("R6 valid done", m_valid, 0);
    chk("R6 pushed", pushes - base, 1);
    ext_req = 0; cyc(6);
    chk("R6 ack low", ext_ack, 0);
    cfg_ack_en = 0;

    // R9 trigger qualifier, rising then falling
    cfg_mode = 0; cfg_trig_en = 1; cfg_trig_fall = 0; base = pushes;
    pacer_tick = 1; cyc(1); pacer_tick = 0; cyc(2);
    chk("R9 blocked before trigger", pushes - base, 0);
    ext_trig = 1; cyc(4);
    chk("R9 rising trigger seen", trig_seen, 1);
    pacer_tick = 1; cyc(1); pacer_tick = 0; cyc(2);
    chk("R9 capture after trigger", pushes - base, 1);
    flush = 1; cyc(1); flush = 0;
    chk("R9 flush disarms", trig_seen, 0);
    cfg_trig_fall = 1; cyc(2); base = pushes;
    pacer_tick = 1; cyc(1); pacer_tick = 0; cyc(2);
    chk("R9 blocked falling", pushes - base, 0);
    ext_trig = 0; cyc(4);
    chk("R9 falling trigger seen", trig_seen, 1);
    pacer_tick = 1; cyc(1); pacer_tick = 0; cyc(2);
    chk("R9 capture after falling", pushes - base, 1);
    cfg_trig_en = 0;

    // R10 mode off
    cfg_mode = 3; base = pushes;
    pacer_tick = 1; cyc(1); pacer_tick = 0;
    ext_req = 1; cyc(8); ext_req = 0; cyc(8);
    chk("R10 no capture", pushes - base, 0);
    chk("R10 no ack", ext_ack, 0);

    finish_run();
  end
endmodule